// File: doc/BRIEF.md
# Audio Slot Mute Generator and Silence Detector

This block sits between a slotted audio serializer and its sample source and sink. Each cycle with `slotValid` high carries one slot: its index, the outgoing transmit sample and the incoming receive sample. `frameEnd` marks the last slot of a frame. On the transmit side the block either passes the sample through or replaces it with a mute word. The mute word is zero, or, for short frames of at most two slots, the same slot's last sample sent before muting began.

On the receive side the block decides, at each frame end, whether the whole frame was silent, meaning every received slot was zero. It counts consecutive silent frames. When that count reaches a 6-bit programmed threshold it sets a sticky detection flag. The flag can be routed to an interrupt through an enable, and it is cleared only by a clear strobe. Slots may arrive back to back or with idle cycles between them.

Top module: `audio_mute_unit`

## Requirements
- R1: With `muteEn` low, a slot accepted at a clock edge appears on `txOut`, equal to `txData`, after that edge, with `txOutValid` high for exactly that one cycle.
- R2: With `muteEn` high and `muteRepeat` low, every accepted slot produces `txOut` = 0.
- R3: With `muteEn` high, `muteRepeat` high and `slotCount` of 1 or 2, slot index 0 or 1 produces the value last sent unmuted on that slot index. This value is 0 if that slot index has not been sent unmuted since reset.
- R4: With `muteEn` high and `slotCount` above 2, every accepted slot produces `txOut` = 0, whatever the value of `muteRepeat`.
- R5: The stored repeat word for slot 0 and slot 1 is updated only by unmuted slots. Muted frames leave it unchanged.
- R6: A frame is silent only if every received slot in it has `rxData` = 0. A frame containing any non-zero slot resets the consecutive-silent count to zero.
- R7: `muteDetected` rises one cycle after the frame-end slot of the frame that brings the consecutive-silent count equal to `muteThresh` (1 to 63). A threshold of 0 never sets it.
- R8: The count saturates at 63 and keeps counting past the threshold. After a detection, the flag is not set again until a non-silent frame has occurred, even if it is cleared.
- R9: `muteDetected` is sticky through later frames of any kind. It returns to 0 only after a cycle with `detClear` high.
- R10: `muteIrq` is high exactly when `muteDetected` and `irqEnable` are both high.
- R11: After reset, `txOut`, `txOutValid`, `muteDetected` and `muteIrq` are 0, and the silent-frame count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slotValid | input | 1 | A slot is present this cycle |
| slotIdx | input | 4 | Index of the slot within its frame |
| frameEnd | input | 1 | This slot is the last of its frame |
| txData | input | 16 | Outgoing sample from the source |
| rxData | input | 16 | Incoming sample from the line |
| slotCount | input | 5 | Number of slots per frame (1 to 16) |
| muteEn | input | 1 | Transmit mute active |
| muteRepeat | input | 1 | Repeat last sample instead of zero (at most 2 slots) |
| muteThresh | input | 6 | Consecutive silent frames needed for detection |
| irqEnable | input | 1 | Routes the detection flag to the interrupt |
| detClear | input | 1 | Clears the detection flag |
| txOut | output | 16 | Transmit sample after mute substitution |
| txOutValid | output | 1 | `txOut` holds a new slot |
| muteDetected | output | 1 | Sticky silence detection flag |
| muteIrq | output | 1 | Detection interrupt |

## Verification
The assertions check on every cycle that unmuted slots pass through unchanged. They also check that muting with more than two slots, or without the repeat option, yields zero, that a non-silent frame clears the count, that the flag rises only after a silent frame end, that it holds until cleared, and that the interrupt never fires without the flag. Only the bench scenarios can show the repeat values themselves. These include that muted frames leave the stored words untouched, that detection lands on exactly the threshold frame across several thresholds and slot counts, and that saturation prevents a second detection until sound returns.

// File: rtl/mute_pkg.sv
`timescale 1ns/1ps
package mute_pkg;
  // End-of-frame event passed from the datapath to the control.
  typedef struct packed {
    logic frameDone;    // a frame-end slot was accepted
    logic frameSilent;  // every received slot of that frame was zero
  } frame_evt_t;
endpackage

// File: rtl/mute_dpath.sv
`timescale 1ns/1ps
module mute_dpath
  import mute_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int MAX_SLOTS    = 16,
  parameter int REPEAT_SLOTS = 2,
  localparam int SLOT_IDX_W  = $clog2(MAX_SLOTS),
  localparam int SCNT_W      = $clog2(MAX_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slotValid,
  input  logic [SLOT_IDX_W-1:0] slotIdx,
  input  logic                  frameEnd,
  input  logic [DATA_W-1:0]     txData,
  input  logic [DATA_W-1:0]     rxData,
  input  logic [SCNT_W-1:0]     slotCount,
  input  logic                  muteEn,
  input  logic                  muteRepeat,
  output logic [DATA_W-1:0]     txOut,
  output logic                  txOutValid,
  output frame_evt_t            evt
);

  logic [DATA_W-1:0] lastWord [REPEAT_SLOTS];
  logic [DATA_W-1:0] muteWord;
  logic              repeatOk;
  logic              loudAcc;
  logic              frameLoud;

  // Per-slot repeat storage, written only by unmuted slots.
  for (genvar g = 0; g < REPEAT_SLOTS; g++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lastWord[g] <= '0;
      else if (slotValid && !muteEn && slotIdx == SLOT_IDX_W'(g))
        lastWord[g] <= txData;
    end
  end

  always_comb begin
    repeatOk = muteRepeat
            && (slotCount <= SCNT_W'(REPEAT_SLOTS))
            && (slotIdx < SLOT_IDX_W'(REPEAT_SLOTS));
    muteWord = '0;
    for (int k = 0; k < REPEAT_SLOTS; k++)
      if (repeatOk && slotIdx == SLOT_IDX_W'(k)) muteWord = lastWord[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txOut      <= '0;
      txOutValid <= 1'b0;
    end else begin
      txOutValid <= slotValid;
      if (slotValid) txOut <= muteEn ? muteWord : txData;
    end
  end

  // Receive side: accumulate "any non-zero slot" across a frame.
  assign frameLoud = loudAcc | (|rxData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loudAcc <= 1'b0;
      evt     <= '0;
    end else begin
      evt.frameDone   <= slotValid && frameEnd;
      evt.frameSilent <= !frameLoud;
      if (slotValid) loudAcc <= frameEnd ? 1'b0 : frameLoud;
    end
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    slotValid && !muteEn |=> txOutValid && txOut == $past(txData));

  a_r2_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    slotValid && muteEn && !muteRepeat |=> txOut == '0);

  a_r4_many_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
    slotValid && muteEn && slotCount > SCNT_W'(REPEAT_SLOTS) |=> txOut == '0);

endmodule

// File: rtl/mute_ctrl.sv
`timescale 1ns/1ps
module mute_ctrl
  import mute_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_evt_t       evt,
  input  logic [CNT_W-1:0] muteThresh,
  input  logic             irqEnable,
  input  logic             detClear,
  output logic             muteDetected,
  output logic             muteIrq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] silentCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             canCount;
  logic             setNow;

  assign canCount = evt.frameDone && evt.frameSilent && (silentCnt != CNT_MAX);
  assign nextCnt  = silentCnt + CNT_W'(1);
  assign setNow   = canCount && (nextCnt == muteThresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      silentCnt <= '0;
    else if (evt.frameDone && !evt.frameSilent)
      silentCnt <= '0;
    else if (canCount)
      silentCnt <= nextCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      muteDetected <= 1'b0;
    else if (setNow)
      muteDetected <= 1'b1;
    else if (detClear)
      muteDetected <= 1'b0;
  end

  assign muteIrq = muteDetected && irqEnable;

  a_r6_loud_resets: assert property (@(posedge clk) disable iff (!rst_n)
    evt.frameDone && !evt.frameSilent |=> silentCnt == '0);

  a_r7_rise_on_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(muteDetected) |-> $past(evt.frameDone && evt.frameSilent));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    silentCnt == CNT_MAX && !(evt.frameDone && !evt.frameSilent) |=> silentCnt == CNT_MAX);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    muteDetected && !detClear |=> muteDetected);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    muteIrq |-> muteDetected && irqEnable);

endmodule

// File: rtl/audio_mute_unit.sv
`timescale 1ns/1ps
module audio_mute_unit
  import mute_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_SLOTS = 16,
  parameter int CNT_W     = 6,
  localparam int SLOT_IDX_W = $clog2(MAX_SLOTS),
  localparam int SCNT_W     = $clog2(MAX_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slotValid,
  input  logic [SLOT_IDX_W-1:0] slotIdx,
  input  logic                  frameEnd,
  input  logic [DATA_W-1:0]     txData,
  input  logic [DATA_W-1:0]     rxData,
  input  logic [SCNT_W-1:0]     slotCount,
  input  logic                  muteEn,
  input  logic                  muteRepeat,
  input  logic [CNT_W-1:0]      muteThresh,
  input  logic                  irqEnable,
  input  logic                  detClear,
  output logic [DATA_W-1:0]     txOut,
  output logic                  txOutValid,
  output logic                  muteDetected,
  output logic                  muteIrq
);

  frame_evt_t frameEvt;

  mute_dpath #(
    .DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .REPEAT_SLOTS(2)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .slotIdx(slotIdx),
    .frameEnd(frameEnd), .txData(txData), .rxData(rxData),
    .slotCount(slotCount), .muteEn(muteEn), .muteRepeat(muteRepeat),
    .txOut(txOut), .txOutValid(txOutValid), .evt(frameEvt)
  );

  mute_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(frameEvt), .muteThresh(muteThresh),
    .irqEnable(irqEnable), .detClear(detClear),
    .muteDetected(muteDetected), .muteIrq(muteIrq)
  );

endmodule

// File: tb/audio_mute_unit_tb.sv
`timescale 1ns/1ps
module audio_mute_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slotValid = 1'b0;
  logic [3:0]  slotIdx = '0;
  logic        frameEnd = 1'b0;
  logic [15:0] txData = '0;
  logic [15:0] rxData = '0;
  logic [4:0]  slotCount = 5'd2;
  logic        muteEn = 1'b0;
  logic        muteRepeat = 1'b0;
  logic [5:0]  muteThresh = '0;
  logic        irqEnable = 1'b0;
  logic        detClear = 1'b0;
  logic [15:0] txOut;
  logic        txOutValid;
  logic        muteDetected;
  logic        muteIrq;

  int errors = 0;
  int checks = 0;

  logic [15:0] mLast [2];
  int          mCnt = 0;
  bit          mFlag = 0;
  bit          mLoud = 0;

  always #4 clk = ~clk;

  audio_mute_unit u_dut (
    .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .slotIdx(slotIdx),
    .frameEnd(frameEnd), .txData(txData), .rxData(rxData),
    .slotCount(slotCount), .muteEn(muteEn), .muteRepeat(muteRepeat),
    .muteThresh(muteThresh), .irqEnable(irqEnable), .detClear(detClear),
    .txOut(txOut), .txOutValid(txOutValid),
    .muteDetected(muteDetected), .muteIrq(muteIrq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One slot: drive at negedge, accepted at posedge, output checked at next negedge.
  task automatic doSlot(input int idx, input logic [15:0] tx, input logic [15:0] rx,
                        input bit last);
    logic [15:0] exp;
    string tag;
    @(negedge clk);
    slotValid = 1'b1; slotIdx = 4'(idx); frameEnd = last; txData = tx; rxData = rx;
    @(posedge clk);
    if (!muteEn) begin
      exp = tx; tag = "R1";
    end else if (slotCount > 2) begin
      exp = '0; tag = "R4";
    end else if (muteRepeat && idx < 2) begin
      exp = mLast[idx]; tag = "R3/R5";
    end else begin
      exp = '0; tag = "R2";
    end
    if (!muteEn && idx < 2) mLast[idx] = tx;
    mLoud = mLoud || (rx != 0);
    if (last) begin
      if (mLoud) mCnt = 0;
      else if (mCnt < 63) begin
        mCnt++;
        if (mCnt == int'(muteThresh)) mFlag = 1;
      end
      mLoud = 0;
    end
    @(negedge clk);
    check({tag, " txOut"}, txOut, exp);
    check("R1 txOutValid", txOutValid, 1);
    slotValid = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic checkFlag(input string tag);
    @(negedge clk);
    check({tag, " muteDetected"}, muteDetected, mFlag);
    check("R10 muteIrq", muteIrq, mFlag && irqEnable);
  endtask

  // silent=1: all rx zero; else one non-zero rx slot at position seed % n.
  task automatic doFrame(input int seed, input bit silent, input string tag);
    int n;
    n = int'(slotCount);
    for (int i = 0; i < n; i++)
      doSlot(i, 16'(seed * 37 + i * 11 + 1),
             (!silent && i == seed % n) ? 16'(seed + 1) : 16'h0, i == n - 1);
    checkFlag(tag);
  endtask

  task automatic doClear();
    @(negedge clk); detClear = 1'b1;
    @(negedge clk); detClear = 1'b0;
    mFlag = 0;
    check("R9 cleared", muteDetected, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tv[5];
    mLast[0] = '0; mLast[1] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 txOut", txOut, 0);
    check("R11 txOutValid", txOutValid, 0);
    check("R11 muteDetected", muteDetected, 0);
    check("R11 muteIrq", muteIrq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle valid", txOutValid, 0);

    // Repeat before any unmuted slot gives 0 (R3).
    slotCount = 5'd2; muteEn = 1'b1; muteRepeat = 1'b1;
    doFrame(90, 0, "R3");

    // Transmit sweep over slot counts and mute modes.
    for (int sc = 1; sc <= 4; sc++) begin
      slotCount = 5'(sc);
      for (int f = 0; f < 6; f++) begin
        int m;
        m = (f == 0 || f == 4) ? 0 : (f == 2 ? 1 : 2);
        muteEn = (m != 0); muteRepeat = (m == 2);
        doFrame(sc * 10 + f, 0, "R6");
      end
    end
    muteEn = 1'b0; muteRepeat = 1'b0;

    // Detection at exact threshold, then saturation (R7, R8).
    irqEnable = 1'b1;
    tv = '{1, 2, 3, 7, 63};
    for (int t = 0; t < 5; t++) begin
      muteThresh = 6'(tv[t]);
      slotCount = (tv[t] == 63) ? 5'd1 : 5'(tv[t] % 4 + 1);
      doFrame(t, 0, "R6");
      for (int k = 0; k < tv[t] + 2; k++) doFrame(k, 1, "R7");
      doClear();
      for (int k = 0; k < 3; k++) doFrame(k, 1, "R8");
      doFrame(t + 5, 0, "R8");
    end

    // Loud frame in the middle resets the count (R6).
    muteThresh = 6'd3; slotCount = 5'd3;
    doFrame(1, 1, "R6"); doFrame(2, 1, "R6");
    doFrame(4, 0, "R6");
    doFrame(3, 1, "R6"); doFrame(5, 1, "R6");
    doFrame(6, 1, "R7");
    // Sticky through loud frames (R9).
    doFrame(7, 0, "R9"); doFrame(8, 0, "R9");
    // Interrupt gating (R10).
    @(negedge clk); irqEnable = 1'b0;
    checkFlag("R10");
    @(negedge clk); irqEnable = 1'b1;
    checkFlag("R10");
    doClear();

    // Threshold 0 never detects (R7).
    muteThresh = 6'd0; slotCount = 5'd2;
    doFrame(2, 0, "R7");
    for (int k = 0; k < 5; k++) doFrame(k, 1, "R7");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule